// File: doc/BRIEF.md
# TDM Channel Blocking Strobe Generator

This block drives a single strobe output that is aligned to the transmit frame of a T1 or E1 time-division line. It serves one port. A bit clock advances a frame-position counter, and a one-cycle frame-sync pulse puts that counter back to the first bit of the frame. Thirty-two enable bits select which channels raise the strobe. Each enabled channel raises it for all eight of its bit times. The enable bits are held in four byte-wide registers, which are written over a simple write-only register bus.

In T1 mode the frame is 193 bits long: one framing bit followed by 24 eight-bit channels. The lowest enable bit of the fourth register does not select a channel in this mode. It decides whether the strobe pulses during the framing bit. In E1 mode the frame is 256 bits long and all 32 bits select timeslots. Downstream logic uses the strobe to mark or gate the selected channels, for example to drop or insert channel data. New register values are adopted only at channel boundaries, so the strobe is always constant across a channel.

Top module: `chblk_strobe_gen`

## Requirements
- R1: After a synchronous reset, all four control registers read as zero and the strobe is low. The strobe stays low while every enable bit is zero.
- R2: A write with `wr_addr` = a (0..3) and data byte d stores d in register a. Bit b of register a enables channel 8·a + b + 1, so bit 0 is the lowest channel of the group.
- R3: When `mode_e1` = 1, the frame is 256 bits. Timeslot t (0..31) occupies frame bits 8t..8t+7 and is controlled by enable bit t, so timeslot 0 is channel 1.
- R4: When `mode_e1` = 0, the frame is 193 bits. Bit 0 is the framing bit, and channel c (1..24) occupies frame bits 8(c−1)+1..8c.
- R5: In T1 mode, bit 0 of register 3 (address 3) raises the strobe for the framing bit when it is 1 and keeps the strobe low there when it is 0.
- R6: In T1 mode, bits 1..7 of register 3 have no effect on the strobe.
- R7: A cycle with `fsync` high is frame bit 0. Without a sync pulse, the position wraps to 0 after the last bit of the frame (bit 192 in T1, bit 255 in E1).
- R8: The strobe is registered. For a frame bit presented in one clock cycle, the strobe shows that bit's value in the next cycle.
- R9: A register write is adopted at the next channel boundary (or the framing bit), and the strobe never changes in the middle of a channel.
- R10: `mode_e1` chooses the frame format for each cycle: 0 selects T1 and 1 selects E1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one frame bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode_e1 | input | 1 | Frame format: 0 = T1 (193 bits), 1 = E1 (256 bits) |
| fsync | input | 1 | Marks the current cycle as frame bit 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index, 0..3 |
| wr_data | input | 8 | Byte written to the selected register |
| strobe | output | 1 | Channel blocking strobe, one cycle behind the frame bit |

## Verification
Several properties are checked on every cycle:
- A write lands in the addressed byte.
- The strobe holds its value unless a channel boundary has just passed.
- In T1 mode, the framing-bit strobe follows the gate bit.
- The frame position advances by one in E1 mode and never goes past bit 192 in T1 mode.

Three kinds of behaviour are shown only by the bench's scenarios, which compare the strobe on every cycle with an independent frame model:
- how each enable bit maps to its channel's bit times;
- the one-cycle latency;
- the deferral of a mid-channel write to the next boundary.

Those scenarios include sync pulses in the middle of a frame, mode changes and reserved bits set in T1 mode.

// File: rtl/chblk_pkg.sv
package chblk_pkg;

    localparam int REG_W      = 8;
    localparam int N_REGS     = 4;
    localparam int N_CH       = REG_W * N_REGS;
    localparam int SLOT_BITS  = 8;
    localparam int SLOT_LG    = $clog2(SLOT_BITS);
    localparam int E1_LEN     = N_CH * SLOT_BITS;
    localparam int T1_CH      = 24;
    localparam int T1_LEN     = T1_CH * SLOT_BITS + 1;
    localparam int POS_W      = $clog2(E1_LEN);
    localparam int CH_W       = $clog2(N_CH);
    localparam int ADDR_W     = $clog2(N_REGS);
    localparam int FBIT_CH    = T1_CH;

    typedef enum logic {
        FRM_T1 = 1'b0,
        FRM_E1 = 1'b1
    } frame_mode_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CH_W-1:0]  chan;
        logic             chan_start;
        logic             fbit;
    } frame_pos_t;

    function automatic logic [POS_W-1:0] frame_last(frame_mode_e m);
        if (m == FRM_E1) return POS_W'(E1_LEN - 1);
        return POS_W'(T1_LEN - 1);
    endfunction

    function automatic frame_pos_t decode_pos(frame_mode_e m, logic [POS_W-1:0] p);
        frame_pos_t       r;
        logic [POS_W-1:0] off;
        r.pos  = p;
        r.fbit = 1'b0;
        if (m == FRM_E1) begin
            off = p;
        end else if (p == '0) begin
            off    = '0;
            r.fbit = 1'b1;
        end else begin
            off = p - 1'b1;
        end
        r.chan       = r.fbit ? CH_W'(FBIT_CH) : off[SLOT_LG +: CH_W];
        r.chan_start = r.fbit | (off[SLOT_LG-1:0] == '0);
        return r;
    endfunction

endpackage

// File: rtl/chblk_frame_counter.sv
module chblk_frame_counter
    import chblk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  frame_mode_e mode,
    input  logic        fsync,
    output frame_pos_t  cur
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    always_comb begin
        if (fsync) begin
            pos_d = '0;
        end else if (pos_q >= frame_last(mode)) begin
            pos_d = '0;
        end else begin
            pos_d = pos_q + 1'b1;
        end
        cur = decode_pos(mode, pos_d);
    end

    // Reset to the top of the range so the first counted bit is bit 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_W'(E1_LEN - 1);
        end else begin
            pos_q <= pos_d;
        end
    end
endmodule

// File: rtl/chblk_regfile.sv
module chblk_regfile
    import chblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [N_CH-1:0]   ctl
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic [REG_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                byte_q <= wr_data;
            end
        end

        assign ctl[g*REG_W +: REG_W] = byte_q;
    end
endmodule

// File: rtl/chblk_strobe_sel.sv
module chblk_strobe_sel
    import chblk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  frame_pos_t      cur,
    input  logic [N_CH-1:0] ctl,
    output logic            strobe
);
    logic [N_CH-1:0] act_q;
    logic [N_CH-1:0] act_d;
    logic            strobe_d;

    // The active copy is refreshed only at a boundary, so the strobe is constant inside a channel.
    always_comb begin
        act_d    = cur.chan_start ? ctl : act_q;
        strobe_d = act_d[cur.chan];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            strobe <= 1'b0;
        end else begin
            act_q  <= act_d;
            strobe <= strobe_d;
        end
    end
endmodule

// File: rtl/chblk_strobe_gen.sv
module chblk_strobe_gen
    import chblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_e1,
    input  logic              fsync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              strobe
);
    frame_mode_e     mode_sel;
    frame_pos_t      cur_pos;
    logic [N_CH-1:0] ctl_bits;

    assign mode_sel = mode_e1 ? FRM_E1 : FRM_T1;

    chblk_frame_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode_sel),
        .fsync (fsync),
        .cur   (cur_pos)
    );

    chblk_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl     (ctl_bits)
    );

    chblk_strobe_sel u_sel (
        .clk    (clk),
        .rst    (rst),
        .cur    (cur_pos),
        .ctl    (ctl_bits),
        .strobe (strobe)
    );
endmodule

// File: rtl/chblk_checks.sv
module chblk_checks
    import chblk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_e1,
    input logic              fsync,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              strobe,
    input frame_pos_t        cur,
    input logic [N_CH-1:0]   ctl
);
    logic              wen_d;
    logic [ADDR_W-1:0] addr_d;
    logic [REG_W-1:0]  data_d;
    logic              rst_d;

    always_ff @(posedge clk) begin
        rst_d  <= rst;
        wen_d  <= wr_en && !rst;
        addr_d <= wr_addr;
        data_d <= wr_data;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        (rst_d === 1'b1) |-> (!strobe && (ctl == '0)));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wen_d === 1'b1) |-> (ctl[addr_d*REG_W +: REG_W] == data_d));

    assert_e1_advance_R3: assert property (@(posedge clk) disable iff (rst)
        ((rst_d === 1'b0) && mode_e1 && $past(mode_e1) && !fsync)
        |-> (cur.pos == POS_W'($past(cur.pos) + 1)));

    assert_t1_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ((rst_d === 1'b0) && !mode_e1 && !$past(mode_e1))
        |-> (cur.pos <= POS_W'(T1_LEN - 1)));

    assert_fbit_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode_e1 && cur.fbit) |=> (strobe == $past(ctl[FBIT_CH])));

    assert_t1_chan_range_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode_e1) |-> (cur.chan <= CH_W'(FBIT_CH)));

    assert_hold_in_channel_R9: assert property (@(posedge clk) disable iff (rst)
        ((rst_d === 1'b0) && !$past(cur.chan_start)) |-> $stable(strobe));
endmodule

bind chblk_strobe_gen chblk_checks u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_e1 (mode_e1),
    .fsync   (fsync),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .strobe  (strobe),
    .cur     (cur_pos),
    .ctl     (ctl_bits)
);

// File: tb/sim_chblk_strobe_gen.sv
module sim_chblk_strobe_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_e1 = 1'b1;
    logic       fsync = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       strobe;

    int n_chk  = 0;
    int n_fail = 0;

    // Frame model built from the requirements.
    int          m_pos  = 255;
    logic [31:0] m_regs = '0;
    logic [31:0] m_act  = '0;
    logic        m_exp  = 1'b0;

    always #2 clk = ~clk;

    chblk_strobe_gen u0 (
        .clk     (clk),
        .rst     (rst),
        .mode_e1 (mode_e1),
        .fsync   (fsync),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .strobe  (strobe)
    );

    function automatic bit slot_begins(bit e1, int pos);
        if (e1) return (pos % 8) == 0;
        return (pos == 0) || (((pos - 1) % 8) == 0);
    endfunction

    function automatic bit want_bit(bit e1, logic [31:0] act, int pos);
        if (e1) return act[pos / 8];
        if (pos == 0) return act[24];
        return act[(pos - 1) / 8];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pos  = 255;
            m_regs = '0;
            m_act  = '0;
            m_exp  = 1'b0;
        end else begin
            int flen;
            flen = mode_e1 ? 256 : 193;
            if (fsync) m_pos = 0;
            else if (m_pos >= flen - 1) m_pos = 0;
            else m_pos = m_pos + 1;
            if (slot_begins(mode_e1, m_pos)) m_act = m_regs;
            m_exp = want_bit(mode_e1, m_act, m_pos);
            if (wr_en) m_regs[wr_addr*8 +: 8] = wr_data;
        end
    end

    task automatic step(input string tag);
        @(negedge clk);
        n_chk++;
        if (strobe !== m_exp) begin
            n_fail++;
            $display("FAIL %s: pos=%0d actual=%b expected=%b", tag, m_pos, strobe, m_exp);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    task automatic sync(input string tag);
        fsync = 1'b1;
        step(tag);
        fsync = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);

        // R1: the strobe is low during reset and with all registers cleared.
        run(4, "R1");
        rst = 1'b0;
        run(300, "R1");

        // R2 and R3: E1 mapping with mixed byte patterns.
        wr(2'd0, 8'hA5, "R2");
        wr(2'd1, 8'h3C, "R2");
        wr(2'd2, 8'h81, "R2");
        wr(2'd3, 8'h7E, "R2");
        sync("R3");
        run(530, "R3");

        // R8: a single channel makes the one-cycle latency visible at its edges.
        wr(2'd0, 8'h01, "R8");
        wr(2'd1, 8'h00, "R8");
        wr(2'd2, 8'h00, "R8");
        wr(2'd3, 8'h00, "R8");
        sync("R8");
        run(270, "R8");

        // R4 and R5: T1 framing with the framing-bit pulse enabled.
        mode_e1 = 1'b0;
        wr(2'd2, 8'h80, "R4");
        wr(2'd3, 8'h01, "R5");
        sync("R5");
        run(400, "R5");
        wr(2'd3, 8'h00, "R5");
        run(200, "R5");

        // R6: reserved bits of the fourth register are set in T1 mode.
        wr(2'd3, 8'hFE, "R6");
        wr(2'd0, 8'h00, "R6");
        wr(2'd2, 8'h00, "R6");
        run(400, "R6");

        // R9: a write in the middle of a channel is deferred to the boundary.
        mode_e1 = 1'b1;
        sync("R9");
        run(3, "R9");
        wr(2'd0, 8'hFF, "R9");
        run(20, "R9");
        wr(2'd1, 8'h00, "R9");
        run(40, "R9");

        // R7: sync pulses inside a frame, followed by free-running wraps.
        run(37, "R7");
        sync("R7");
        run(100, "R7");
        sync("R7");
        run(600, "R7");

        // R10: mode changes in the middle of a frame.
        mode_e1 = 1'b0;
        run(250, "R10");
        mode_e1 = 1'b1;
        run(250, "R10");

        // R10 and R9: random writes, syncs and mode changes.
        for (int k = 0; k < 20000; k++) begin
            if (($urandom % 16) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 2'($urandom % 4);
                wr_data = 8'($urandom);
            end
            if (($urandom % 400) == 0) fsync = 1'b1;
            if (($urandom % 3000) == 0) mode_e1 = ~mode_e1;
            step("R10");
            wr_en = 1'b0;
            fsync = 1'b0;
        end

        // R1: reset again in the middle of traffic.
        rst = 1'b1;
        run(3, "R1");
        rst = 1'b0;
        run(50, "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule